// File: doc/BRIEF.md
# Run-Length Configuration Bit Expander

This block turns a stream of one-byte compressed codes into the serial bit stream that a device's serial configuration port expects. Bytes come in on a valid/ready interface. Bits go out on a one-bit valid/ready stream. After reset, or after a one-cycle start pulse, the block first sends a fixed 16-bit sync word, 0xFF then 0x20, most significant bit first. It then takes codes one at a time.

Each code describes either a run of ones or a run of zeros plus an optional closing bit of the other value. The ranges are split around a fixed threshold of 226. While a code is being expanded, the input is held off. The next byte is taken only after the last bit of the current code has been accepted downstream.

Top module: `rle_bit_expander`

## Requirements
- R1: After reset the output sends the sync word bits 1,1,1,1,1,1,1,1,0,0,1,0,0,0,0,0 in that order. During this time in_ready is low. The first bit is presented in the first cycle after reset.
- R2: A code n with 1 <= n <= 226 expands to n one-bits followed by a single zero-bit.
- R3: Code 227 expands to exactly 226 one-bits and has no closing zero.
- R4: A code n with 228 <= n <= 254 expands to (n - 228) zero-bits followed by a single one-bit, so code 228 gives only a one.
- R5: Code 255 expands to a single one-bit.
- R6: Code 0 produces no output bits. It is consumed in one cycle, and in_ready is high again in the next cycle.
- R7: in_ready is low from the cycle after a non-zero code is accepted until its last bit is accepted downstream. It is high in the cycle after that. out_valid is high exactly while bits are pending.
- R8: While out_valid is high and out_ready is low, out_valid and out_bit hold their values into the next cycle.
- R9: A start pulse has priority over everything else. In that cycle in_ready is low and no bit is consumed. Any unfinished expansion is dropped, and the sync word is sent again from its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that restarts the sync word |
| in_valid | input | 1 | A code byte is offered |
| in_data | input | 8 | Compressed code byte |
| in_ready | output | 1 | The block takes the offered byte at this edge |
| out_valid | output | 1 | A serial bit is offered |
| out_ready | input | 1 | Downstream takes the offered bit at this edge |
| out_bit | output | 1 | Serial configuration bit |

## Verification
The sharpest collision is a start pulse landing in the same cycle as a downstream handshake or an input byte offer. Both are provoked deliberately. The start is raised mid-run with out_ready high, and again while the block is idle with in_valid high. The bench judges these cases by requiring in_ready low in that cycle, by counting no bit as consumed, and by expecting a fresh sync word next. The other collision is the last bit of one code being accepted while the next byte waits. A full sweep over all 256 codes under irregular out_ready checks that the new code is taken only in the following cycle and that its bits follow with no gap in the expected sequence.

// File: rtl/rle_exp_pkg.sv
`timescale 1ns/1ps
// Shared types for the run-length bit expander.
// Assumes one-byte codes; the code width is fixed here for all users.
package rle_exp_pkg;
    localparam int CODE_W = 8;

    typedef enum logic [1:0] {
        ST_SYNC,
        ST_IDLE,
        ST_RUN,
        ST_TAIL
    } seq_state_t;

    // How one code expands: a run of identical bits, then an optional closing bit.
    typedef struct packed {
        logic [CODE_W-1:0] run_len;
        logic              run_bit;
        logic              has_tail;
        logic              tail_bit;
    } code_plan_t;
endpackage

// File: rtl/rle_code_decode.sv
`timescale 1ns/1ps
// Classifies one code byte into a run length, run value and closing bit.
// Purely combinational. Assumes ONES_MAX + 2 < 2**CODE_W - 1 so that all four ranges exist.
module rle_code_decode
    import rle_exp_pkg::*;
#(
    parameter int ONES_MAX = 226
) (
    input  logic [CODE_W-1:0] code,
    output code_plan_t        plan
);
    localparam logic [CODE_W-1:0] K_ONES      = CODE_W'(ONES_MAX);
    localparam logic [CODE_W-1:0] K_ONES_OPEN = CODE_W'(ONES_MAX + 1);
    localparam logic [CODE_W-1:0] K_ZERO_BASE = CODE_W'(ONES_MAX + 2);
    localparam logic [CODE_W-1:0] K_SINGLE    = '1;

    // Range split: ones+zero, open ones, zeros+one, lone one; zero is empty.
    always_comb begin
        plan = '0;
        if (code == '0) begin
            plan = '0;
        end else if (code <= K_ONES) begin
            plan.run_len  = code;
            plan.run_bit  = 1'b1;
            plan.has_tail = 1'b1;
            plan.tail_bit = 1'b0;
        end else if (code == K_ONES_OPEN) begin
            plan.run_len  = K_ONES;
            plan.run_bit  = 1'b1;
        end else if (code != K_SINGLE) begin
            plan.run_len  = code - K_ZERO_BASE;
            plan.run_bit  = 1'b0;
            plan.has_tail = 1'b1;
            plan.tail_bit = 1'b1;
        end else begin
            plan.has_tail = 1'b1;
            plan.tail_bit = 1'b1;
        end
    end
endmodule

// File: rtl/rle_down_counter.sv
`timescale 1ns/1ps
// Loadable down counter with a flag for the final step.
// Assumes the owner never decrements at zero; load wins over decrement.
module rle_down_counter #(
    parameter int W         = 8,
    parameter int RESET_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         at_one
);
    // Counter register: reset, load or step down.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= W'(RESET_VAL);
        else if (load) count <= load_val;
        else if (dec)  count <= count - 1'b1;
    end

    assign at_one = (count == W'(1));

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (count != '0));
endmodule

// File: rtl/rle_bit_expander.sv
`timescale 1ns/1ps
// Expands compressed configuration codes into a serial bit stream.
// Sends a sync word after reset or start, then one code at a time; input is
// stalled during expansion. Assumes downstream may stall out_ready freely.
module rle_bit_expander
    import rle_exp_pkg::*;
#(
    parameter int                ONES_MAX     = 226,
    parameter int                SYNC_W       = 16,
    parameter logic [SYNC_W-1:0] SYNC_PATTERN = 16'hFF20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_bit
);
    localparam int SYNC_CW = $clog2(SYNC_W + 1);

    seq_state_t         state_q, state_d;
    code_plan_t         plan;
    logic               run_bit_q, has_tail_q, tail_bit_q;
    logic               in_fire, out_fire;
    logic [SYNC_CW-1:0] sync_cnt, sync_idx;
    logic               sync_last;
    logic [CODE_W-1:0]  run_cnt;
    logic               run_last;

    rle_code_decode #(.ONES_MAX(ONES_MAX)) u_decode (
        .code (in_data),
        .plan (plan)
    );

    rle_down_counter #(.W(SYNC_CW), .RESET_VAL(SYNC_W)) u_sync_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (SYNC_CW'(SYNC_W)),
        .dec      (out_fire && (state_q == ST_SYNC)),
        .count    (sync_cnt),
        .at_one   (sync_last)
    );

    rle_down_counter #(.W(CODE_W), .RESET_VAL(0)) u_run_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (in_fire),
        .load_val (plan.run_len),
        .dec      (out_fire && (state_q == ST_RUN)),
        .count    (run_cnt),
        .at_one   (run_last)
    );

    // Handshakes; a start pulse suppresses both.
    assign in_ready  = (state_q == ST_IDLE) && !start;
    assign in_fire   = in_valid && in_ready;
    assign out_valid = (state_q != ST_IDLE);
    assign out_fire  = out_valid && out_ready && !start;
    assign sync_idx  = sync_cnt - 1'b1;

    // Output bit selection by phase.
    always_comb begin
        case (state_q)
            ST_SYNC: out_bit = SYNC_PATTERN[sync_idx];
            ST_RUN:  out_bit = run_bit_q;
            ST_TAIL: out_bit = tail_bit_q;
            default: out_bit = 1'b0;
        endcase
    end

    // Phase sequencing.
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_SYNC;
        end else begin
            case (state_q)
                ST_SYNC: if (out_fire && sync_last) state_d = ST_IDLE;
                ST_IDLE: if (in_fire) begin
                    if (plan.run_len != '0) state_d = ST_RUN;
                    else if (plan.has_tail) state_d = ST_TAIL;
                end
                ST_RUN:  if (out_fire && run_last) state_d = has_tail_q ? ST_TAIL : ST_IDLE;
                ST_TAIL: if (out_fire) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SYNC;
        else        state_q <= state_d;
    end

    // Captures the bit values of the accepted code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_bit_q  <= 1'b0;
            has_tail_q <= 1'b0;
            tail_bit_q <= 1'b0;
        end else if (in_fire) begin
            run_bit_q  <= plan.run_bit;
            has_tail_q <= plan.has_tail;
            tail_bit_q <= plan.tail_bit;
        end
    end

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_bit)));

    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && (in_data != '0)) |=> !in_ready);

    assert_zero_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && (in_data == '0)) |=> !out_valid);

    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (out_valid && !in_ready && (out_bit == SYNC_PATTERN[SYNC_W-1])));
endmodule

// File: tb/tb_rle_bit_expander.sv
`timescale 1ns/1ps
module tb_rle_bit_expander;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_ready = 1'b0;
    logic       in_ready, out_valid, out_bit;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    bit    q_bit[$];
    string q_tag[$];
    bit    hold_pending = 0;
    bit    hold_bit = 0;

    always #2 clk = ~clk;

    rle_bit_expander dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int c);
        if (c == 0)   return "R6";
        if (c <= 226) return "R2";
        if (c == 227) return "R3";
        if (c <= 254) return "R4";
        return "R5";
    endfunction

    // Reference expansion computed from the code ranges.
    task automatic push_code(input int c);
        string t = tag_of(c);
        if (c >= 1 && c <= 226) begin
            for (int i = 0; i < c; i++) begin q_bit.push_back(1'b1); q_tag.push_back(t); end
            q_bit.push_back(1'b0); q_tag.push_back(t);
        end else if (c == 227) begin
            for (int i = 0; i < 226; i++) begin q_bit.push_back(1'b1); q_tag.push_back(t); end
        end else if (c >= 228 && c <= 254) begin
            for (int i = 0; i < c - 228; i++) begin q_bit.push_back(1'b0); q_tag.push_back(t); end
            q_bit.push_back(1'b1); q_tag.push_back(t);
        end else if (c == 255) begin
            q_bit.push_back(1'b1); q_tag.push_back(t);
        end
    endtask

    task automatic push_sync();
        logic [15:0] w = 16'hFF20;
        for (int i = 15; i >= 0; i--) begin q_bit.push_back(w[i]); q_tag.push_back("R1"); end
    endtask

    // One clock: drive inputs after the falling edge, judge the coming rising edge.
    task automatic cycle(input bit st, input bit iv, input int d, input bit ordy,
                         output bit accepted);
        bit busy;
        @(negedge clk);
        start = st; in_valid = iv; in_data = 8'(d); out_ready = ordy;
        #1;
        accepted = 0;
        if (hold_pending && !st)
            check(out_valid && (out_bit == hold_bit), "R8", "held bit",
                  int'(out_bit), int'(hold_bit));
        if (st) begin
            check(!in_ready, "R9", "in_ready during start", int'(in_ready), 0);
            q_bit.delete(); q_tag.delete();
            push_sync();
            hold_pending = 0;
        end else begin
            busy = (q_bit.size() != 0);
            check(in_ready == !busy, busy ? "R7" : "R6", "in_ready", int'(in_ready), int'(!busy));
            check(out_valid == busy, "R7", "out_valid", int'(out_valid), int'(busy));
            if (out_valid && ordy && busy) begin
                string t = q_tag.pop_front();
                bit    e = q_bit.pop_front();
                check(out_bit == e, t, "out_bit", int'(out_bit), int'(e));
            end
            hold_pending = out_valid && !ordy;
            hold_bit = out_bit;
            if (iv && in_ready) begin
                push_code(d);
                accepted = 1;
            end
        end
    endtask

    task automatic send(input int c);
        bit acc = 0;
        if (c % 7 == 3) cycle(0, 0, 0, ($urandom_range(0, 3) != 0), acc);
        acc = 0;
        while (!acc) cycle(0, 1, c, ($urandom_range(0, 3) != 0), acc);
    endtask

    task automatic drain();
        bit acc;
        while (q_bit.size() != 0) cycle(0, 0, 0, ($urandom_range(0, 3) != 0), acc);
        cycle(0, 0, 0, 1, acc);
    endtask

    initial begin
        bit acc;
        int picks[13] = '{0, 255, 0, 1, 226, 227, 228, 229, 254, 255, 0, 0, 2};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state presents the first sync bit with the input held off
        check(out_valid == 1'b1, "R1", "out_valid after reset", int'(out_valid), 1);
        check(out_bit == 1'b1, "R1", "first sync bit", int'(out_bit), 1);
        check(in_ready == 1'b0, "R1", "in_ready after reset", int'(in_ready), 0);
        push_sync();

        // Full sweep over every code value (R2..R6).
        for (int c = 0; c < 256; c++) send(c);
        drain();

        // Boundary codes in a different order with back-to-back offers.
        foreach (picks[k]) send(picks[k]);
        drain();

        // R9: start in the middle of a long run, with out_ready high.
        send(200);
        for (int i = 0; i < 5; i++) cycle(0, 0, 0, 1, acc);
        cycle(1, 0, 0, 1, acc);
        drain();

        // R9: start while idle with a byte offered; the byte must not be taken.
        cycle(1, 1, 5, 1, acc);
        check(acc == 0, "R9", "byte taken during start", int'(acc), 0);
        drain();

        // R9: start on the cycle of the closing bit of code 1.
        send(1);
        cycle(0, 0, 0, 1, acc);
        cycle(1, 0, 0, 1, acc);
        drain();
        send(230);
        drain();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule